// File: doc/BRIEF.md
# Receive Buffer Ring Index Controller

This block tracks a circular ring of receive buffer descriptors shared between a host and the receive path. Software supplies empty buffers by moving a write index forward in steps of eight. The block keeps its own fill index, which names the descriptor currently being filled. Each time a buffer is closed, the block advances the fill index, reports the closed descriptor through a status write-back strobe and can raise an interrupt. A buffer closes on end of frame, when it reaches its configured size, or when no data has arrived for a programmed number of timer ticks.

The receive datapath delivers data as fixed-size chunks on `fill_i`, with `eof_i` marking the last chunk of a frame. `ready_o` tells the datapath whether a chunk would be accepted now. One 32-bit configuration word holds the channel mode, the ring-size exponent, the buffer size, the interrupt target and the timeout. A second register holds the write index. Fetching descriptors from memory and moving data are outside this block.

Top module: `rx_ring_ctrl`

## Requirements
- R1: After reset the write and fill indices are 0, so `ready_o` is 0. `wb_valid_o` and `irq_o` are 0, and `rx_status_o` reads 0x0100_0000 (idle flag in bit 24, all other bits 0).
- R2: A write with `reg_sel_i`=1 loads the write index from `reg_wdata_i[11:0]`. The value is masked to the ring size and its low three bits are ignored.
- R3: The ring holds 2^E entries, where E is config bits [23:20] clamped to the range 5..12. The fill index wraps from 2^E-1 to 0.
- R4: When the fill index equals the write index, `ready_o` is 0 and chunks on `fill_i` are dropped without any write-back.
- R5: An accepted chunk with `eof_i`=1 closes the buffer. On the next cycle `wb_valid_o` pulses for one cycle and `wb_index_o` carries the closed descriptor's index.
- R6: Config bits [17:16] select the buffer size as 64×(sel+1) chunks (00=4K, 01=8K, 10=12K, 11=16K at 64-byte chunks). The chunk that fills the buffer closes it, even without `eof_i`.
- R7: Config bits [11:4] hold the timeout T. A partly filled buffer closes on the T-th `tick_i` after its most recent accepted chunk. Each accepted chunk restarts the count, and T=0 disables the timeout.
- R8: Config bits [13:12] select the interrupt target. With 01, `irq_o` pulses together with every `wb_valid_o` pulse. Any other value gives no interrupt.
- R9: Config bits [31:30]=00 (and the unused code 11) stop the channel at once. `ready_o` drops, later chunks are ignored, and a partly filled buffer is discarded without advancing the fill index. Idle is shown within two cycles.
- R10: Config bits [31:30]=01 pauses at end of frame. A frame already in progress keeps being accepted until its `eof_i`, which produces the write-back. The idle flag rises one cycle after that write-back, and no new frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the configuration word, 1 the write index |
| reg_wdata_i | input | 32 | Register write data |
| tick_i | input | 1 | Timeout time-base tick (one per timeout unit) |
| fill_i | input | 1 | One data chunk written to the current buffer |
| eof_i | input | 1 | Qualifies `fill_i`: last chunk of the frame |
| ready_o | output | 1 | A chunk offered now would be accepted |
| wb_valid_o | output | 1 | Status write-back strobe, one cycle per closed buffer |
| wb_index_o | output | 12 | Index of the descriptor just closed |
| irq_o | output | 1 | Interrupt pulse to the host |
| rx_status_o | output | 32 | Status word, bit 24 is the idle flag |

## Verification
The hardest cases to reach from the ports are a wrap of the fill index and a full ring. The default ring has 256 entries, so the bench first runs with an exponent below the legal minimum. That forces the 32-entry ring, and refilling it to 31 and back to 0 takes only a few dozen frames. Mid-frame mode changes need a buffer already open when the configuration word is rewritten. The bench therefore leaves one chunk without an end-of-frame marker in place before writing the stop or pause code. It then watches whether the next write-back reuses the same index (stop) or closes that same buffer (pause).

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int TMO_W = 8;

  typedef enum logic [1:0] {
    EN_STOP      = 2'b00,
    EN_PAUSE_EOF = 2'b01,
    EN_RUN       = 2'b10,
    EN_RSVD      = 2'b11
  } rx_en_e;

  typedef struct packed {
    rx_en_e           en;
    logic [3:0]       exp;
    logic [1:0]       bsel;
    logic [1:0]       dest;
    logic [TMO_W-1:0] tmo;
  } rx_cfg_t;

  function automatic rx_cfg_t decode_cfg(input logic [31:0] w);
    rx_cfg_t c;
    c.en   = rx_en_e'(w[31:30]);
    c.exp  = w[23:20];
    c.bsel = w[17:16];
    c.dest = w[13:12];
    c.tmo  = w[11:4];
    return c;
  endfunction

endpackage

// File: rtl/rxr_cfg.sv
module rxr_cfg
  import rxr_pkg::*;
#(
  parameter int IDX_W     = 12,
  parameter int MIN_EXP   = 5,
  parameter int MAX_EXP   = 12,
  parameter int STEP_LOG2 = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [31:0]      wdata_i,
  output rx_cfg_t          cfg_o,
  output logic [IDX_W-1:0] mask_o,
  output logic [IDX_W-1:0] wr_idx_o
);

  localparam logic [IDX_W-1:0] ALIGN_M = ~IDX_W'((1 << STEP_LOG2) - 1);

  rx_cfg_t          cfg_q;
  logic [IDX_W-1:0] wr_q;
  logic [3:0]       exp_c;
  logic [IDX_W:0]   span;
  logic             unused_bits;

  assign unused_bits = ^{wdata_i[29:24], wdata_i[19:18], wdata_i[15:14], span[IDX_W]};

  always_comb begin
    if (cfg_q.exp < 4'(MIN_EXP))      exp_c = 4'(MIN_EXP);
    else if (cfg_q.exp > 4'(MAX_EXP)) exp_c = 4'(MAX_EXP);
    else                              exp_c = cfg_q.exp;
  end

  assign span     = (IDX_W+1)'(1) << exp_c;
  assign mask_o   = span[IDX_W-1:0] - IDX_W'(1);
  assign wr_idx_o = wr_q & mask_o;
  assign cfg_o    = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      wr_q  <= '0;
    end else if (we_i) begin
      if (!sel_i) cfg_q <= decode_cfg(wdata_i);
      else        wr_q  <= wdata_i[IDX_W-1:0] & mask_o & ALIGN_M;
    end
  end

endmodule

// File: rtl/rxr_fill.sv
module rxr_fill
  import rxr_pkg::*;
#(
  parameter int CHUNKS_4K = 64,
  localparam int CNT_W    = $clog2(4 * CHUNKS_4K + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pause_i,
  input  logic             room_i,
  input  logic             fill_i,
  input  logic             eof_i,
  input  logic             tick_i,
  input  logic [1:0]       bsel_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             close_o,
  output logic             in_frame_o
);

  logic             in_frame_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc, cap;
  logic [TMO_W-1:0] tmo_q;
  logic             allowed, accept, close_full, close_eof, tmo_hit;

  assign allowed    = run_i | (pause_i & in_frame_q);
  assign accept     = allowed & fill_i & room_i;
  assign cap        = CNT_W'(CHUNKS_4K) * (CNT_W'(bsel_i) + CNT_W'(1));
  assign cnt_inc    = cnt_q + CNT_W'(1);
  assign close_full = accept & (cnt_inc >= cap);
  assign close_eof  = accept & eof_i;
  // ticks only age a buffer that holds data and got no chunk this cycle
  assign tmo_hit    = (run_i | pause_i) & ~accept & (cnt_q != '0) & tick_i &
                      (tmo_i != '0) & (tmo_q == tmo_i - TMO_W'(1));
  assign close_o    = close_full | close_eof | tmo_hit;
  assign in_frame_o = in_frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      tmo_q      <= '0;
    end else if (!run_i && !pause_i) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      tmo_q      <= '0;
    end else begin
      if (fill_i && allowed) in_frame_q <= ~eof_i;
      if (close_o)     cnt_q <= '0;
      else if (accept) cnt_q <= cnt_inc;
      if (close_o || accept)             tmo_q <= '0;
      else if (tick_i && cnt_q != '0)    tmo_q <= tmo_q + TMO_W'(1);
    end
  end

  p_eof_empties_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && eof_i) |=> (cnt_q == '0));

endmodule

// File: rtl/rxr_ring.sv
module rxr_ring #(
  parameter int IDX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             close_i,
  input  logic [IDX_W-1:0] mask_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output logic             room_o,
  output logic             wb_valid_o,
  output logic [IDX_W-1:0] wb_index_o
);

  logic [IDX_W-1:0] rd_q, wb_index_q;
  logic             wb_valid_q;

  // equal indices mean nothing left to fill
  assign room_o     = (rd_q != wr_idx_i);
  assign wb_valid_o = wb_valid_q;
  assign wb_index_o = wb_index_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q       <= '0;
      wb_index_q <= '0;
      wb_valid_q <= 1'b0;
    end else begin
      wb_valid_q <= close_i;
      if (close_i) begin
        wb_index_q <= rd_q;
        rd_q       <= (rd_q + IDX_W'(1)) & mask_i;
      end
    end
  end

  p_no_overrun_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |-> (rd_q != wr_idx_i));

endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rxr_pkg::*;
#(
  parameter int IDX_W     = 12,
  parameter int MIN_EXP   = 5,
  parameter int MAX_EXP   = 12,
  parameter int STEP_LOG2 = 3,
  parameter int CHUNKS_4K = 64,
  parameter int IDLE_BIT  = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [31:0]      reg_wdata_i,
  input  logic             tick_i,
  input  logic             fill_i,
  input  logic             eof_i,
  output logic             ready_o,
  output logic             wb_valid_o,
  output logic [IDX_W-1:0] wb_index_o,
  output logic             irq_o,
  output logic [31:0]      rx_status_o
);

  rx_cfg_t          cfg;
  logic [IDX_W-1:0] mask, wr_idx;
  logic             run, pause, room, close, in_frame;
  logic             idle_q, irq_q;

  assign run   = (cfg.en == EN_RUN);
  assign pause = (cfg.en == EN_PAUSE_EOF);

  rxr_cfg #(
    .IDX_W(IDX_W), .MIN_EXP(MIN_EXP), .MAX_EXP(MAX_EXP), .STEP_LOG2(STEP_LOG2)
  ) i_cfg (
    .clk_i, .rst_ni, .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .cfg_o(cfg), .mask_o(mask), .wr_idx_o(wr_idx)
  );

  rxr_fill #(.CHUNKS_4K(CHUNKS_4K)) i_fill (
    .clk_i, .rst_ni, .run_i(run), .pause_i(pause), .room_i(room),
    .fill_i, .eof_i, .tick_i, .bsel_i(cfg.bsel), .tmo_i(cfg.tmo),
    .close_o(close), .in_frame_o(in_frame)
  );

  rxr_ring #(.IDX_W(IDX_W)) i_ring (
    .clk_i, .rst_ni, .close_i(close), .mask_i(mask), .wr_idx_i(wr_idx),
    .room_o(room), .wb_valid_o, .wb_index_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      idle_q <= ~run & ~in_frame;
      irq_q  <= close & (cfg.dest == 2'b01);
    end
  end

  assign ready_o     = room & (run | (pause & in_frame));
  assign irq_o       = irq_q;
  assign rx_status_o = 32'(idle_q) << IDLE_BIT;

  p_irq_with_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wb_valid_o);

  p_idle_after_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_q) |-> (!$past(in_frame) && !$past(run)));

endmodule

// File: tb/test_rx_ring_ctrl.sv
module test_rx_ring_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, reg_sel_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic        tick_i = 1'b0, fill_i = 1'b0, eof_i = 1'b0;
  logic        ready_o, wb_valid_o, irq_o;
  logic [11:0] wb_index_o;
  logic [31:0] rx_status_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_ring_ctrl i_rx_ring_ctrl (
    .clk_i(clk), .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i, .tick_i,
    .fill_i, .eof_i, .ready_o, .wb_valid_o, .wb_index_o, .irq_o, .rx_status_o
  );

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr_cfg(input logic [1:0] en, input logic [3:0] ex, input logic [1:0] bs,
                        input logic [1:0] dst, input logic [7:0] tmo);
    reg_we_i = 1; reg_sel_i = 0;
    reg_wdata_i = {en, 6'b0, ex, 2'b0, bs, 2'b0, dst, tmo, 4'b0};
    @(negedge clk); reg_we_i = 0;
  endtask

  task automatic wr_idx(input logic [11:0] v);
    reg_we_i = 1; reg_sel_i = 1; reg_wdata_i = {20'h0, v};
    @(negedge clk); reg_we_i = 0;
  endtask

  task automatic push(input logic e, output logic v, output logic [11:0] ix, output logic irq);
    fill_i = 1; eof_i = e;
    @(negedge clk); fill_i = 0; eof_i = 0;
    v = wb_valid_o; ix = wb_index_o; irq = irq_o;
  endtask

  task automatic tick(output logic v, output logic [11:0] ix, output logic irq);
    tick_i = 1;
    @(negedge clk); tick_i = 0;
    v = wb_valid_o; ix = wb_index_o; irq = irq_o;
  endtask

  task automatic t_reset();
    chk("R1 ready", ready_o, 0);
    chk("R1 wb_valid", wb_valid_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 status", rx_status_o, 32'h0100_0000);
  endtask

  task automatic t_basic();
    logic v, q; logic [11:0] ix;
    wr_cfg(2'b10, 4'd8, 2'b00, 2'b01, 8'd0);
    wr_idx(12'h80D);                      // masked to 0x0D, aligned to 8
    chk("R1 status after enable", rx_status_o, 0);
    chk("R2 ready after write", ready_o, 1);
    for (int k = 0; k < 8; k++) begin
      push(1'b1, v, ix, q);
      chk("R5 wb_valid", v, 1);
      chk("R5 wb_index", ix, k);
      chk("R8 irq with dest 01", q, 1);
    end
    chk("R4 ready when full", ready_o, 0);
    push(1'b1, v, ix, q);
    chk("R4 dropped chunk", v, 0);
  endtask

  task automatic t_wrap();
    logic v, q; logic [11:0] ix;
    int bad = 0;
    wr_cfg(2'b10, 4'd2, 2'b00, 2'b00, 8'd0); // clamps to 32 entries
    wr_idx(12'h000);
    for (int k = 8; k < 32; k++) begin
      push(1'b1, v, ix, q);
      if (!v || ix != 12'(k) || q) bad++;
    end
    chk("R3 wrap sequence 8..31", bad, 0);
    chk("R8 no irq with dest 00", q, 0);
    chk("R3 full after wrap", ready_o, 0);
    wr_cfg(2'b10, 4'd12, 2'b00, 2'b01, 8'd0);
    wr_idx(12'h800);
    chk("R3 4096-entry ring keeps bit 11", ready_o, 1);
  endtask

  task automatic t_bufsize();
    logic v, q; logic [11:0] ix;
    int early = 0;
    wr_cfg(2'b10, 4'd8, 2'b01, 2'b01, 8'd0);
    wr_idx(12'h010);
    for (int k = 0; k < 127; k++) begin push(1'b0, v, ix, q); if (v) early++; end
    push(1'b0, v, ix, q);
    chk("R6 8K no early close", early, 0);
    chk("R6 8K close on 128th", v, 1);
    chk("R6 8K index", ix, 0);
    wr_cfg(2'b10, 4'd8, 2'b00, 2'b01, 8'd0);
    early = 0;
    for (int k = 0; k < 63; k++) begin push(1'b0, v, ix, q); if (v) early++; end
    push(1'b0, v, ix, q);
    chk("R6 4K no early close", early, 0);
    chk("R6 4K close index", ix, 1);
    push(1'b1, v, ix, q);
    chk("R5 frame tail close", ix, 2);
  endtask

  task automatic t_timeout();
    logic v, q; logic [11:0] ix;
    wr_cfg(2'b10, 4'd8, 2'b00, 2'b01, 8'd3);
    push(1'b0, v, ix, q);
    tick(v, ix, q); chk("R7 tick1", v, 0);
    tick(v, ix, q); chk("R7 tick2", v, 0);
    tick(v, ix, q);
    chk("R7 close on 3rd tick", v, 1);
    chk("R7 index", ix, 3);
    chk("R8 irq on timeout", q, 1);
    push(1'b0, v, ix, q);
    tick(v, ix, q); tick(v, ix, q);
    push(1'b0, v, ix, q);
    tick(v, ix, q); tick(v, ix, q);
    chk("R7 restart by chunk", v, 0);
    tick(v, ix, q);
    chk("R7 close after restart", ix, 4);
    chk("R7 close after restart valid", v, 1);
    wr_cfg(2'b10, 4'd8, 2'b00, 2'b01, 8'd0);
    push(1'b0, v, ix, q);
    for (int k = 0; k < 5; k++) begin
      tick(v, ix, q);
      chk("R7 zero disables", v, 0);
    end
    push(1'b1, v, ix, q);
    chk("R7 eof after disabled", ix, 5);
  endtask

  task automatic t_stop();
    logic v, q; logic [11:0] ix;
    push(1'b0, v, ix, q);                 // buffer 6 partly filled
    wr_cfg(2'b00, 4'd8, 2'b00, 2'b01, 8'd0);
    chk("R9 ready after stop", ready_o, 0);
    push(1'b1, v, ix, q);
    chk("R9 chunk ignored", v, 0);
    @(negedge clk);
    chk("R9 idle flag", rx_status_o, 32'h0100_0000);
    wr_cfg(2'b10, 4'd8, 2'b00, 2'b01, 8'd0);
    push(1'b1, v, ix, q);
    chk("R9 partial discarded index", ix, 6);
    chk("R9 restart valid", v, 1);
  endtask

  task automatic t_pause();
    logic v, q; logic [11:0] ix;
    push(1'b0, v, ix, q);                 // buffer 7 open
    wr_cfg(2'b01, 4'd8, 2'b00, 2'b01, 8'd0);
    @(negedge clk);
    chk("R10 not idle mid-frame", rx_status_o, 0);
    push(1'b0, v, ix, q);
    chk("R10 chunk accepted no close", v, 0);
    push(1'b1, v, ix, q);
    chk("R10 eof write-back", v, 1);
    chk("R10 eof index", ix, 7);
    chk("R10 idle after write-back", rx_status_o, 0);
    @(negedge clk);
    chk("R10 idle raised", rx_status_o, 32'h0100_0000);
    chk("R10 ready low", ready_o, 0);
    push(1'b1, v, ix, q);
    chk("R10 new frame refused", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_bufsize();
    t_timeout();
    t_stop();
    t_pause();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule